// File: doc/BRIEF.md
# Serial Avionics Word Transmitter with Two-Step Host Loading

This block takes 32-bit avionics data words from a 16-bit host bus and sends them on a two-wire serial line as return-to-zero pulses. The host places the lower half of a word on the bus and pulses the first-half strobe. It then places the upper half on the bus and pulses the second-half strobe. The completed word goes into an eight-entry transmit queue. A serializer takes words from the queue and sends each one as 32 bits. It sends the 8-bit label field most significant bit first, then the remaining bits in ascending order, and it always replaces the last bit with odd parity. The line outputs are digital HI / LO / NULL drive levels for an external line driver.

The bit rate comes from the master clock divided by 10 or by 80, chosen by a single rate-select input. The same divided clock is also provided as an output. An enable input controls whether a queued word may begin. A flag stays low while any word is queued or being sent, and goes high again once the line has fallen quiet.

The host strobes are plain control pins, not a valid/ready stream. There is no back-pressure. A host that loads a ninth word while eight are queued loses that word, so the host is expected to pace its loads using the flag.

Top module: `a429_tx_host`

## Requirements
- R1: A first-half strobe copies `host_data` into word bits 15:0, where bits 7:0 are the label. A repeated first-half strobe overwrites the pending half. A second-half strobe copies `host_data` into bits 31:16 and queues the word only if a first half is pending. With no first half pending, the second-half strobe is ignored.
- R2: Strobes are sampled one per clock. When both strobes are high in one cycle, the second-half strobe first completes and queues any pending word. The first-half strobe then starts a new word with the same bus value.
- R3: `tx_empty` is low from the first clock edge after a word has been queued.
- R4: `tx_empty` returns high only when the queue is empty and the serializer has finished its last word, including the trailing four NULL bit periods. This is 4.5 bit periods after the last bit's drive half ends.
- R5: `tx_clk` has a period of 10 clocks when `rate_slow`=0 and 80 clocks when `rate_slow`=1. It is high for the first half of each period. A change of `rate_slow` takes effect at the next period boundary.
- R6: A queued word starts only at a bit boundary while `tx_en` is high. With `tx_en` low, queued words are held. A word that has already started always completes.
- R7: A word goes out in this order: bits 7 down to 0, then bits 8 up to 30, then the parity bit.
- R8: The 32nd bit sent is odd parity over word bits 30:0. The host's bit 31 is discarded.
- R9: A one is sent as `line_hi`=1 and a zero as `line_lo`=1, each for the first half of the bit period. The line is NULL (both low) for the second half. Both outputs are never high together.
- R10: When words are queued back to back, exactly four NULL bit periods separate the end of one word's last bit period from the start of the next word.
- R11: The queue holds 8 words. A completing second-half strobe while 8 words are queued drops that word and clears the pending half.
- R12: `rst_n` low clears the queue, the pending half and the serializer. After reset the line is NULL, `tx_empty` is high, and words queued before the reset are never sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_data | input | 16 | Host bus half-word |
| load_lo | input | 1 | First-half strobe (word bits 15:0) |
| load_hi | input | 1 | Second-half strobe (word bits 31:16), queues the word |
| tx_en | input | 1 | Permits a queued word to begin |
| rate_slow | input | 1 | 0: divide by 10, 1: divide by 80 |
| tx_clk | output | 1 | Divided bit clock |
| line_hi | output | 1 | Drive HI level to line driver |
| line_lo | output | 1 | Drive LO level to line driver |
| tx_empty | output | 1 | High when nothing is queued or in flight |

## Verification
The two host strobes can land in the same cycle. In that cycle, completing a pending word and opening a new first half must both happen, and they share one bus value. The bench holds both strobes high for a single clock with a distinct value on the bus, then completes the second word with another value. It decodes both words from the line and compares each against the upper and lower halves it expects. A queue push can also coincide with a serializer pop. The back-to-back sweep provokes this repeatedly, and it is judged by the word count and the 4.5-bit-period separation between words.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

  localparam int WORD_W  = 32;
  localparam int HALF_W  = 16;
  localparam int LABEL_W = 8;

  typedef enum logic [1:0] {
    LV_NULL = 2'b00,
    LV_HI   = 2'b01,
    LV_LO   = 2'b10
  } line_lvl_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_SEND = 2'b01,
    ST_GAP  = 2'b10
  } ser_state_e;

  // Reorders a host word into line order: element 0 leaves first.
  // Label goes out msb-first, the data field lsb-first, parity last.
  function automatic logic [WORD_W-1:0] line_order(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] s;
    for (int i = 0; i < LABEL_W; i++) s[i] = w[LABEL_W-1-i];
    for (int i = LABEL_W; i < WORD_W-1; i++) s[i] = w[i];
    s[WORD_W-1] = ~^w[WORD_W-2:0];
    return s;
  endfunction

endpackage

// File: rtl/a429_bitclk.sv
module a429_bitclk #(
  parameter int DIV_FAST = 10,
  parameter int DIV_SLOW = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_slow,
  output logic tx_clk,
  output logic bit_tick,
  output logic half_tick
);

  localparam int MAXD = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int CW   = $clog2(MAXD + 1);
  localparam logic [CW-1:0] LIM_F = CW'(DIV_FAST);
  localparam logic [CW-1:0] LIM_S = CW'(DIV_SLOW);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_q;
  logic [CW-1:0] half_w;

  assign half_w    = lim_q >> 1;
  assign bit_tick  = (cnt_q == lim_q - CW'(1));
  assign half_tick = (cnt_q == half_w - CW'(1));
  assign tx_clk    = (cnt_q < half_w);

  // The ratio is only adopted at a period boundary, so a period never tears.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= LIM_F;
    end else if (bit_tick) begin
      cnt_q <= '0;
      lim_q <= rate_slow ? LIM_S : LIM_F;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> (cnt_q == '0));

  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q < lim_q));

endmodule

// File: rtl/a429_load_fifo.sv
module a429_load_fifo
  import a429_tx_pkg::*;
#(
  parameter int DEPTH = 8   // power of two
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] host_data,
  input  logic              load_lo,
  input  logic              load_hi,
  input  logic              pop,
  output logic [WORD_W-1:0] word_out,
  output logic              empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

  logic [HALF_W-1:0] stage_q;
  logic              stage_v_q;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [AW:0]       count_q;
  logic              full, push_req, push;

  assign full     = (count_q == DEPTH_C);
  assign empty    = (count_q == '0);
  assign push_req = load_hi && stage_v_q;
  assign push     = push_req && !full;
  assign word_out = mem[rd_ptr_q];

  // Staging half: the second strobe consumes the pending half even when dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q   <= '0;
      stage_v_q <= 1'b0;
    end else if (load_lo) begin
      stage_q   <= host_data;
      stage_v_q <= 1'b1;
    end else if (load_hi) begin
      stage_v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= {host_data, stage_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (pop)  rd_ptr_q <= rd_ptr_q + AW'(1);
      if (push && !pop)      count_q <= count_q + (AW+1)'(1);
      else if (pop && !push) count_q <= count_q - (AW+1)'(1);
    end
  end

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop) |=> (count_q == DEPTH_C));

  p_orphan_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!stage_v_q && load_hi && !pop) |=> $stable(count_q));

  p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count_q != '0));

endmodule

// File: rtl/a429_serializer.sv
module a429_serializer
  import a429_tx_pkg::*;
#(
  parameter int GAP_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              half_tick,
  input  logic              tx_en,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_word,
  output logic              pop,
  output logic              line_hi,
  output logic              line_lo,
  output logic              idle
);

  localparam int GW = $clog2(GAP_BITS + 1);
  localparam int IW = $clog2(WORD_W);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_BITS - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(WORD_W - 1);

  ser_state_e        st_q;
  line_lvl_e         lvl_q;
  logic [IW-1:0]     idx_q;
  logic [GW-1:0]     gcnt_q;
  logic [WORD_W-1:0] shreg_q;
  logic [WORD_W-1:0] seq_w;
  logic              can_start;

  assign seq_w     = line_order(fifo_word);
  assign can_start = (st_q == ST_IDLE) || ((st_q == ST_GAP) && (gcnt_q == GAP_LAST));
  assign pop       = bit_tick && can_start && tx_en && !fifo_empty;
  assign line_hi   = (lvl_q == LV_HI);
  assign line_lo   = (lvl_q == LV_LO);
  assign idle      = (st_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      lvl_q   <= LV_NULL;
      idx_q   <= '0;
      gcnt_q  <= '0;
      shreg_q <= '0;
    end else if (bit_tick) begin
      if (can_start) begin
        if (pop) begin
          shreg_q <= seq_w >> 1;
          lvl_q   <= seq_w[0] ? LV_HI : LV_LO;
          idx_q   <= '0;
          st_q    <= ST_SEND;
        end else begin
          st_q  <= ST_IDLE;
          lvl_q <= LV_NULL;
        end
      end else if (st_q == ST_SEND) begin
        if (idx_q == IDX_LAST) begin
          st_q   <= ST_GAP;
          gcnt_q <= '0;
          lvl_q  <= LV_NULL;
        end else begin
          idx_q   <= idx_q + IW'(1);
          lvl_q   <= shreg_q[0] ? LV_HI : LV_LO;
          shreg_q <= shreg_q >> 1;
        end
      end else if (st_q == ST_GAP) begin
        gcnt_q <= gcnt_q + GW'(1);
      end
    end else if (half_tick) begin
      lvl_q <= LV_NULL;
    end
  end

  p_start_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && bit_tick && !tx_en) |=> (st_q == ST_IDLE));

  p_return_null_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != LV_NULL && half_tick) |=> (lvl_q == LV_NULL));

  p_gap_null_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP) |-> (lvl_q == LV_NULL));

  p_word_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEND && bit_tick && idx_q == IDX_LAST) |=> (st_q == ST_GAP));

endmodule

// File: rtl/a429_tx_host.sv
module a429_tx_host
  import a429_tx_pkg::*;
#(
  parameter int DIV_FAST   = 10,
  parameter int DIV_SLOW   = 80,
  parameter int FIFO_DEPTH = 8,
  parameter int GAP_BITS   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] host_data,
  input  logic        load_lo,
  input  logic        load_hi,
  input  logic        tx_en,
  input  logic        rate_slow,
  output logic        tx_clk,
  output logic        line_hi,
  output logic        line_lo,
  output logic        tx_empty
);

  logic              bit_tick, half_tick;
  logic              pop, fifo_empty, ser_idle;
  logic [WORD_W-1:0] fifo_word;

  a429_bitclk #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_clk (
    .clk(clk), .rst_n(rst_n), .rate_slow(rate_slow),
    .tx_clk(tx_clk), .bit_tick(bit_tick), .half_tick(half_tick)
  );

  a429_load_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .host_data(host_data),
    .load_lo(load_lo), .load_hi(load_hi), .pop(pop),
    .word_out(fifo_word), .empty(fifo_empty)
  );

  a429_serializer #(.GAP_BITS(GAP_BITS)) u_ser (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .half_tick(half_tick),
    .tx_en(tx_en), .fifo_empty(fifo_empty), .fifo_word(fifo_word),
    .pop(pop), .line_hi(line_hi), .line_lo(line_lo), .idle(ser_idle)
  );

  assign tx_empty = fifo_empty && ser_idle;

  p_busy_after_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !tx_empty);

endmodule

// File: tb/sim_a429_tx_host.sv
module sim_a429_tx_host;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] host_data = '0;
  logic        load_lo = 1'b0, load_hi = 1'b0, tx_en = 1'b0, rate_slow = 1'b0;
  logic        tx_clk, line_hi, line_lo, tx_empty;

  always #(CLK_PERIOD/2) clk = ~clk;

  a429_tx_host u0 (
    .clk(clk), .rst_n(rst_n), .host_data(host_data), .load_lo(load_lo),
    .load_hi(load_hi), .tx_en(tx_en), .rate_slow(rate_slow), .tx_clk(tx_clk),
    .line_hi(line_hi), .line_lo(line_lo), .tx_empty(tx_empty)
  );

  int checks = 0, errors = 0;

  // ---------------- line monitor ----------------
  int          n_cur = 10;
  logic        prev_drv = 1'b0, drv;
  int          run = 0, bitn = 0, cur_gap = 0;
  logic [31:0] sb;
  logic [31:0] rx_word [0:255];
  int          gap_before [0:255];
  int          rx_cnt = 0, pw_err = 0, nb_err = 0, both_err = 0, pulse_total = 0;
  logic        trk = 1'b0, empty_at_decode = 1'b0;
  int          trk_cnt = 0, empty_delay = -1;

  function automatic logic [31:0] decode(input logic [31:0] s);
    logic [31:0] w;
    for (int i = 0; i < 8; i++) w[7-i] = s[i];
    for (int i = 8; i < 32; i++) w[i] = s[i];
    return w;
  endfunction

  function automatic logic [31:0] expect_word(input logic [31:0] w);
    return {~^w[30:0], w[30:0]};
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_drv = 1'b0; run = 0; bitn = 0; trk = 1'b0;
    end else begin
      drv = line_hi | line_lo;
      if (line_hi && line_lo) both_err++;
      if (trk) begin
        trk_cnt++;
        if (tx_empty) begin empty_delay = trk_cnt; trk = 1'b0; end
      end
      if (drv && !prev_drv) begin
        pulse_total++; trk = 1'b0;
        if (bitn == 0) cur_gap = run;
        else if (run != n_cur - n_cur/2) nb_err++;
        sb[bitn] = line_hi; bitn++; run = 1;
      end else if (!drv && prev_drv) begin
        if (run != n_cur/2) pw_err++;
        run = 1;
        if (bitn == 32) begin
          rx_word[rx_cnt % 256]    = decode(sb);
          gap_before[rx_cnt % 256] = cur_gap;
          rx_cnt++; bitn = 0;
          empty_at_decode = tx_empty; trk = 1'b1; trk_cnt = 0; empty_delay = -1;
        end
      end else begin
        run++;
      end
      prev_drv = drv;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_word(input logic [31:0] w);
    @(negedge clk); host_data = w[15:0];  load_lo = 1'b1;
    @(negedge clk); load_lo = 1'b0; host_data = w[31:16]; load_hi = 1'b1;
    @(negedge clk); load_hi = 1'b0;
  endtask

  task automatic wait_rx(input int target, input int limit);
    for (int t = 0; t < limit && rx_cnt < target; t++) @(negedge clk);
  endtask

  task automatic measure_txclk(output int per, output int hi);
    int r1, r2, f;
    logic pv;
    r1 = -1; r2 = -1; f = -1; pv = tx_clk;
    for (int t = 0; t < 400 && r2 < 0; t++) begin
      @(negedge clk);
      if (tx_clk && !pv) begin if (r1 < 0) r1 = t; else r2 = t; end
      if (!tx_clk && pv && r1 >= 0 && f < 0) f = t;
      pv = tx_clk;
    end
    per = r2 - r1; hi = f - r1;
  endtask

  function automatic logic [31:0] pattern(input int k);
    if (k < 32)  return 32'h1 << k;
    if (k == 32) return 32'h0;
    if (k == 33) return 32'hFFFF_FFFF;
    if (k == 34) return 32'h5A5A_C3C3;
    return (32'(k) * 32'h9E37_79B9) ^ 32'h1357_0000;
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  logic [31:0] exp_w [0:63];
  int base, nld, pt, per, hi, e0, e1, e2;

  initial begin
    tick(4); rst_n = 1'b1; tick(2);
    check("R12 reset tx_empty", tx_empty, 1);
    check("R12 reset line_hi", line_hi, 0);
    check("R12 reset line_lo", line_lo, 0);

    measure_txclk(per, hi);
    check("R5 fast period", per, 10);
    check("R5 fast high time", hi, 5);

    // Sweep: back-to-back words, walking ones and arithmetic patterns
    tx_en = 1'b1; base = rx_cnt; nld = 0;
    e0 = pw_err; e1 = nb_err; e2 = both_err;
    for (int k = 0; k < 40; k++) begin
      while (nld - (rx_cnt - base) >= 7) @(negedge clk);
      load_word(pattern(k));
      if (k == 0) check("R3 flag low after load", tx_empty, 0);
      exp_w[k] = pattern(k); nld++;
    end
    wait_rx(base + 40, 40 * 400 + 2000);
    check("R7 sweep word count", rx_cnt - base, 40);
    for (int k = 0; k < 40; k++) begin
      check("R7 bit order", {1'b0, rx_word[(base+k)%256][30:0]}, {1'b0, exp_w[k][30:0]});
      check("R8 parity", rx_word[(base+k)%256][31], expect_word(exp_w[k])[31]);
      if (k > 0) check("R10 inter-word null span", gap_before[(base+k)%256], 45);
    end
    check("R9 pulse width", pw_err - e0, 0);
    check("R9 null half", nb_err - e1, 0);
    check("R9 never both", both_err - e2, 0);
    tick(80);
    check("R4 flag low at last bit", empty_at_decode, 0);
    check("R4 flag rise delay", empty_delay, 45);

    // Orphan second half and first-half overwrite (R1)
    pt = pulse_total;
    @(negedge clk); host_data = 16'hFFFF; load_hi = 1'b1;
    @(negedge clk); load_hi = 1'b0;
    check("R1 orphan strobe no queue", tx_empty, 1);
    tick(400);
    check("R1 orphan strobe no line", pulse_total - pt, 0);
    base = rx_cnt;
    @(negedge clk); host_data = 16'h1111; load_lo = 1'b1;
    @(negedge clk); host_data = 16'h2A2B;
    @(negedge clk); load_lo = 1'b0; host_data = 16'h9C3D; load_hi = 1'b1;
    @(negedge clk); load_hi = 1'b0;
    wait_rx(base + 1, 1000);
    check("R1 overwrite word", rx_word[base%256], expect_word(32'h9C3D_2A2B));

    // Both strobes in one cycle (R2)
    base = rx_cnt;
    @(negedge clk); host_data = 16'h1234; load_lo = 1'b1;
    @(negedge clk); host_data = 16'hBEEF; load_hi = 1'b1;
    @(negedge clk); load_lo = 1'b0; host_data = 16'h7777;
    @(negedge clk); load_hi = 1'b0;
    wait_rx(base + 2, 1500);
    check("R2 completed word", rx_word[base%256], expect_word(32'hBEEF_1234));
    check("R2 new word", rx_word[(base+1)%256], expect_word(32'h7777_BEEF));

    // Enable gating (R6)
    tick(100);
    tx_en = 1'b0; base = rx_cnt; pt = pulse_total;
    load_word(32'h0F0F_1E2D);
    check("R3 flag low while held", tx_empty, 0);
    tick(500);
    check("R6 held while disabled", pulse_total - pt, 0);
    tx_en = 1'b1;
    wait_rx(base + 1, 1000);
    check("R6 sent after enable", rx_word[base%256], expect_word(32'h0F0F_1E2D));
    tick(100);
    pt = pulse_total;
    load_word(32'hA0B1_C2D3);
    while (pulse_total == pt) @(negedge clk);
    tx_en = 1'b0;
    load_word(32'h4455_6677);
    wait_rx(base + 2, 1000);
    check("R6 started word completes", rx_word[(base+1)%256], expect_word(32'hA0B1_C2D3));
    tick(600);
    check("R6 second word held", rx_cnt - base, 2);
    check("R4 flag low while held", tx_empty, 0);
    tx_en = 1'b1;
    wait_rx(base + 3, 1000);
    check("R6 held word released", rx_word[(base+2)%256], expect_word(32'h4455_6677));

    // Full queue drops (R11)
    tick(100);
    tx_en = 1'b0; base = rx_cnt;
    for (int k = 0; k < 10; k++) load_word(32'hC0DE_0000 + 32'(k) * 32'h0111_0111);
    tx_en = 1'b1;
    wait_rx(base + 8, 8 * 400 + 500);
    tick(800);
    check("R11 only depth words sent", rx_cnt - base, 8);
    for (int k = 0; k < 8; k++)
      check("R11 kept word", rx_word[(base+k)%256],
            expect_word(32'hC0DE_0000 + 32'(k) * 32'h0111_0111));
    check("R4 flag high after drain", tx_empty, 1);

    // Slow rate (R5, R9, R10)
    rate_slow = 1'b1; tick(30);
    measure_txclk(per, hi);
    check("R5 slow period", per, 80);
    check("R5 slow high time", hi, 40);
    n_cur = 80; base = rx_cnt; e0 = pw_err; e1 = nb_err;
    load_word(32'h8000_00C5);
    load_word(32'h0123_4567);
    wait_rx(base + 2, 2 * 36 * 80 + 400);
    check("R7 slow word 0", rx_word[base%256], expect_word(32'h8000_00C5));
    check("R7 slow word 1", rx_word[(base+1)%256], expect_word(32'h0123_4567));
    check("R10 slow null span", gap_before[(base+1)%256], 360);
    check("R9 slow pulse width", pw_err - e0, 0);
    check("R9 slow null half", nb_err - e1, 0);
    tick(500);
    rate_slow = 1'b0; tick(200); n_cur = 10;

    // Reset clears queue and staging (R12)
    tx_en = 1'b0;
    load_word(32'h1357_9BDF);
    load_word(32'h2468_ACE0);
    @(negedge clk); host_data = 16'h5555; load_lo = 1'b1;
    @(negedge clk); load_lo = 1'b0;
    rst_n = 1'b0; tick(3);
    check("R12 flag during reset", tx_empty, 1);
    check("R12 line null in reset", {line_hi, line_lo}, 0);
    rst_n = 1'b1; tick(2);
    tx_en = 1'b1; pt = pulse_total;
    @(negedge clk); host_data = 16'h6666; load_hi = 1'b1;
    @(negedge clk); load_hi = 1'b0;
    tick(800);
    check("R12 queued words discarded", pulse_total - pt, 0);
    check("R12 flag high after reset", tx_empty, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule